// File: doc/BRIEF.md
# NAND Page SEC-DED Hamming ECC Engine

This block computes a single-error-correcting, double-error-detecting Hamming code over the bytes of a NAND page as they stream past the memory port, one 512-byte block at a time. It keeps one code slot per block, for up to four blocks. A 2 KB page fills all four slots. On a program, software copies the finished codes into the spare area behind the data. On a read, the codes stored in the spare area are presented back, one block at a time. The engine forms the syndrome against its own fresh code and records whether that block was clean, held one correctable data bit (with its location), held a single flipped code bit, or was beyond repair.

Each page starts on its own. When a command is seen whose access address has a zero offset within a 512-byte block, the engine resets its block index and byte count and begins accumulating. A command at any other offset leaves the engine untouched. A last strobe closes a block before 512 bytes. Per-block results stay held until a clear pulse removes them.

Top module: `nand_secded_ecc`

## Requirements
- R1: For each block the 24-bit code holds 12 parity pairs. Pair k (k = 0..11) covers the bit address a = byte_index*8 + bit_index. Bit 2k is the XOR of all data bits whose address bit k is 0, and bit 2k+1 is the XOR of those whose address bit k is 1.
- R2: A pulse of `cmd_vld` with `cmd_off` equal to zero starts a page. On the next cycle `busy` is 1, `code_done` is all zero, and the block index and byte count restart at zero. A pulse with a nonzero offset changes nothing.
- R3: A block closes on its 512th byte, or earlier on a byte that carries `byte_last`. On the cycle after the closing byte, that block's slot of `code_out` holds its code and its `code_done` bit is 1. The next block then counts from byte 0.
- R4: After the fourth block closes, `busy` returns to 0. Bytes offered while `busy` is 0 have no effect on any output.
- R5: A `chk_vld` pulse for block `chk_idx` whose `code_done` bit is set forms syndrome = code XOR `chk_code` and sets that block's `res_vld` on the next cycle. A zero syndrome leaves `res_corr`, `res_unc` and `res_cerr` at 0.
- R6: When both bits of every pair in the syndrome differ, `res_corr` is set. `res_loc` then holds the odd-half bits of the syndrome, which equals byte_index*8 + bit_index of the bad data bit.
- R7: When exactly one syndrome bit is set, `res_cerr` is set, marking an error inside the stored code.
- R8: Any other nonzero syndrome sets `res_unc`. At most one of the three flags is set per block.
- R9: A `chk_vld` pulse for a block whose `code_done` bit is 0 leaves every result unchanged.
- R10: `res_clr` clears all result flags and locations on the next cycle, and wins over a `chk_vld` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_vld | input | 1 | Read or program command seen on the memory port |
| cmd_off | input | 9 | Offset of the command address within a 512-byte block |
| byte_vld | input | 1 | A data byte is on `byte_dat` |
| byte_dat | input | 8 | Data byte |
| byte_last | input | 1 | This byte ends the current block |
| chk_vld | input | 1 | Stored code for block `chk_idx` is on `chk_code` |
| chk_idx | input | 2 | Block the stored code belongs to |
| chk_code | input | 24 | Code read back from the spare area |
| res_clr | input | 1 | Clear all per-block results |
| busy | output | 1 | A page is being accumulated |
| code_done | output | 4 | Per block: code is complete |
| code_out | output | 96 | Codes, block i in bits [24i+23:24i] |
| res_vld | output | 4 | Per block: a check result is held |
| res_corr | output | 4 | Per block: one correctable data bit |
| res_unc | output | 4 | Per block: uncorrectable error |
| res_cerr | output | 4 | Per block: single error in the stored code |
| res_loc | output | 48 | Per block bit address of the bad bit, block i in [12i+11:12i] |

## Verification
Every result in this block lands exactly one cycle after its stimulus. A command sets `busy` one edge later. A closing byte fills its code slot one edge later. A stored-code pulse or a clear changes the flags one edge later. The bench drives inputs on the falling edge and drops each stimulus at the next falling edge. It reads outputs at that same falling edge, which is the first point after the single register stage has taken the update. Ignored stimulus (an unaligned command, idle bytes, a check on an unfinished block) is judged at that same point, by comparing the outputs with their prior values.

// File: rtl/nand_secded_ecc.sv
module nand_secded_ecc #(
  parameter int BLK_BYTES = 512,
  parameter int NBLK      = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cmd_vld,
  input  logic [$clog2(BLK_BYTES)-1:0]          cmd_off,
  input  logic                                  byte_vld,
  input  logic [7:0]                            byte_dat,
  input  logic                                  byte_last,
  input  logic                                  chk_vld,
  input  logic [$clog2(NBLK)-1:0]               chk_idx,
  input  logic [2*($clog2(BLK_BYTES)+3)-1:0]    chk_code,
  input  logic                                  res_clr,
  output logic                                  busy,
  output logic [NBLK-1:0]                       code_done,
  output logic [NBLK*2*($clog2(BLK_BYTES)+3)-1:0] code_out,
  output logic [NBLK-1:0]                       res_vld,
  output logic [NBLK-1:0]                       res_corr,
  output logic [NBLK-1:0]                       res_unc,
  output logic [NBLK-1:0]                       res_cerr,
  output logic [NBLK*($clog2(BLK_BYTES)+3)-1:0] res_loc
);
  localparam int CNT_W  = $clog2(BLK_BYTES);
  localparam int IDX_W  = $clog2(NBLK);
  localparam int NPAIR  = CNT_W + 3;
  localparam int CODE_W = 2 * NPAIR;

  function automatic logic [CODE_W-1:0] byte_term(input logic [7:0] d,
                                                  input logic [CNT_W-1:0] n);
    logic [CODE_W-1:0] t;
    logic p;
    t = '0;
    p = ^d;
    for (int k = 0; k < 3; k++)
      for (int b = 0; b < 8; b++)
        if (((b >> k) & 1) != 0) t[2*k+1] = t[2*k+1] ^ d[b];
        else                     t[2*k]   = t[2*k]   ^ d[b];
    for (int j = 0; j < CNT_W; j++)
      if (n[j]) t[2*(j+3)+1] = p;
      else      t[2*(j+3)]   = p;
    return t;
  endfunction

  logic [CODE_W-1:0] acc, acc_nxt, syn;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  blk;
  logic [CODE_W-1:0] code_q [NBLK];
  logic [NPAIR-1:0]  loc_q  [NBLK];
  logic [NPAIR-1:0]  syn_loc;
  logic              all_diff, one_bit, blk_end, start;

  assign start   = cmd_vld && (cmd_off == '0);
  assign acc_nxt = acc ^ byte_term(byte_dat, cnt);
  assign blk_end = byte_last || (cnt == CNT_W'(BLK_BYTES - 1));
  assign syn     = code_q[chk_idx] ^ chk_code;
  assign one_bit = ($countones(syn) == 1);

  always_comb begin
    all_diff = 1'b1;
    for (int k = 0; k < NPAIR; k++) begin
      all_diff   = all_diff & (syn[2*k] ^ syn[2*k+1]);
      syn_loc[k] = syn[2*k+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      blk       <= '0;
      cnt       <= '0;
      acc       <= '0;
      code_done <= '0;
      for (int i = 0; i < NBLK; i++) code_q[i] <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      blk       <= '0;
      cnt       <= '0;
      acc       <= '0;
      code_done <= '0;
    end else if (busy && byte_vld) begin
      if (blk_end) begin
        code_q[blk]    <= acc_nxt;
        code_done[blk] <= 1'b1;
        acc            <= '0;
        cnt            <= '0;
        blk            <= blk + 1'b1;
        if (blk == IDX_W'(NBLK - 1)) busy <= 1'b0;
      end else begin
        acc <= acc_nxt;
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= '0;
      res_corr <= '0;
      res_unc  <= '0;
      res_cerr <= '0;
      for (int i = 0; i < NBLK; i++) loc_q[i] <= '0;
    end else if (res_clr) begin
      res_vld  <= '0;
      res_corr <= '0;
      res_unc  <= '0;
      res_cerr <= '0;
      for (int i = 0; i < NBLK; i++) loc_q[i] <= '0;
    end else if (chk_vld && code_done[chk_idx]) begin
      res_vld[chk_idx]  <= 1'b1;
      res_corr[chk_idx] <= (syn != '0) && all_diff;
      res_cerr[chk_idx] <= one_bit;
      res_unc[chk_idx]  <= (syn != '0) && !all_diff && !one_bit;
      loc_q[chk_idx]    <= all_diff ? syn_loc : '0;
    end
  end

  for (genvar i = 0; i < NBLK; i++) begin : g_flat
    assign code_out[i*CODE_W +: CODE_W] = code_q[i];
    assign res_loc[i*NPAIR +: NPAIR]    = loc_q[i];
  end
endmodule

// File: rtl/nand_secded_ecc_chk.sv
module nand_secded_ecc_chk #(
  parameter int BLK_BYTES = 512,
  parameter int NBLK      = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cmd_vld,
  input logic [$clog2(BLK_BYTES)-1:0] cmd_off,
  input logic                         chk_vld,
  input logic                         res_clr,
  input logic                         busy,
  input logic [NBLK-1:0]              code_done,
  input logic [NBLK-1:0]              res_vld,
  input logic [NBLK-1:0]              res_corr,
  input logic [NBLK-1:0]              res_unc,
  input logic [NBLK-1:0]              res_cerr
);
  // R2
  aligned_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_off == '0) |=> (busy && code_done == '0));

  // R2
  unaligned_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_vld && cmd_off != '0) |=> !busy);

  // R3
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> ((code_done & $past(code_done)) == $past(code_done)));

  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> code_done[NBLK-1]);

  // R9
  res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_vld && !res_clr) |=> $stable(res_vld));

  // R10
  res_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_clr |=> (res_vld == '0 && res_corr == '0 && res_unc == '0 && res_cerr == '0));

  for (genvar i = 0; i < NBLK; i++) begin : g_excl
    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({res_corr[i], res_unc[i], res_cerr[i]}));
  end
endmodule

bind nand_secded_ecc nand_secded_ecc_chk #(.BLK_BYTES(BLK_BYTES), .NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_off(cmd_off),
  .chk_vld(chk_vld), .res_clr(res_clr), .busy(busy), .code_done(code_done),
  .res_vld(res_vld), .res_corr(res_corr), .res_unc(res_unc), .res_cerr(res_cerr)
);

// File: tb/sim_nand_secded_ecc.sv
`timescale 1ns/1ps
module sim_nand_secded_ecc;
  logic        clk = 0, rst_n = 0;
  logic        cmd_vld = 0, byte_vld = 0, byte_last = 0, chk_vld = 0, res_clr = 0;
  logic [8:0]  cmd_off = 0;
  logic [7:0]  byte_dat = 0;
  logic [1:0]  chk_idx = 0;
  logic [23:0] chk_code = 0;
  logic        busy;
  logic [3:0]  code_done, res_vld, res_corr, res_unc, res_cerr;
  logic [95:0] code_out;
  logic [47:0] res_loc;

  int checks = 0, errors = 0;
  logic [7:0] buf_q [512];

  always #5 clk = ~clk;

  nand_secded_ecc u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(int n);
    logic [23:0] c = '0;
    for (int a = 0; a < n * 8; a++) begin
      logic v = buf_q[a / 8][a % 8];
      for (int k = 0; k < 12; k++)
        if (((a >> k) & 1) != 0) c[2*k+1] ^= v;
        else                     c[2*k]   ^= v;
    end
    return c;
  endfunction

  task automatic fill(int seed);
    for (int i = 0; i < 512; i++) buf_q[i] = 8'((i * seed) ^ (i >> 3) ^ (seed * 37));
  endtask

  task automatic send(int n, bit use_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld  = 1;
      byte_dat  = buf_q[i];
      byte_last = use_last && (i == n - 1);
    end
    @(negedge clk);
    byte_vld = 0; byte_last = 0;
  endtask

  task automatic command(logic [8:0] off);
    @(negedge clk); cmd_vld = 1; cmd_off = off;
    @(negedge clk); cmd_vld = 0;
  endtask

  task automatic stored(logic [1:0] idx, logic [23:0] c);
    @(negedge clk); chk_vld = 1; chk_idx = idx; chk_code = c;
    @(negedge clk); chk_vld = 0;
  endtask

  task automatic t_reset;
    check("R2 reset busy", 32'(busy), 0);
    check("R3 reset code_done", 32'(code_done), 0);
    check("R5 reset res_vld", 32'(res_vld), 0);
  endtask

  task automatic t_ignored;
    command(9'h104);
    check("R2 unaligned busy", 32'(busy), 0);
    fill(5);
    send(20, 1);
    check("R4 idle bytes code_done", 32'(code_done), 0);
    check("R4 idle bytes code slot0", 32'(code_out[23:0]), 0);
  endtask

  task automatic t_full_page;
    logic [23:0] exp;
    command(9'h000);
    check("R2 aligned busy", 32'(busy), 1);
    for (int b = 0; b < 4; b++) begin
      fill(b * 7 + 3);
      exp = model(512);
      send(512, 0);
      check("R1 block code", 32'(code_out[b*24 +: 24]), 32'(exp));
      check("R3 code_done", 32'(code_done), 32'((1 << (b + 1)) - 1));
    end
    check("R4 busy after last block", 32'(busy), 0);
  endtask

  task automatic t_short_block;
    logic [23:0] exp;
    command(9'h000);
    check("R2 restart code_done", 32'(code_done), 0);
    fill(11);
    exp = model(100);
    send(100, 1);
    check("R3 early close code", 32'(code_out[23:0]), 32'(exp));
    check("R3 early close done", 32'(code_done), 1);
    fill(13);
    exp = model(512);
    send(512, 0);
    check("R3 count restarts code", 32'(code_out[47:24]), 32'(exp));
  endtask

  task automatic t_compare;
    logic [23:0] good [4];
    command(9'h000);
    fill(21); good[0] = model(512); send(512, 0);
    fill(22); good[1] = model(512); buf_q[300][5] = ~buf_q[300][5]; send(512, 0);
    fill(23); good[2] = model(512);
    buf_q[7][0] = ~buf_q[7][0]; buf_q[400][6] = ~buf_q[400][6]; send(512, 0);
    fill(24); good[3] = model(512); send(512, 0);
    stored(0, good[0]);
    check("R5 clean vld", 32'(res_vld), 1);
    check("R5 clean flags", 32'({res_corr[0], res_unc[0], res_cerr[0]}), 0);
    stored(1, good[1]);
    check("R6 single corr", 32'(res_corr), 2);
    check("R6 location", 32'(res_loc[23:12]), 300 * 8 + 5);
    stored(2, good[2]);
    check("R8 double unc", 32'(res_unc), 4);
    stored(3, good[3] ^ 24'h000020);
    check("R7 code bit cerr", 32'(res_cerr), 8);
    check("R8 flags exclusive", 32'(res_corr & res_unc | res_corr & res_cerr | res_unc & res_cerr), 0);
  endtask

  task automatic t_clear;
    @(negedge clk); res_clr = 1; chk_vld = 1; chk_idx = 1; chk_code = 0;
    @(negedge clk); res_clr = 0; chk_vld = 0;
    check("R10 clear vld", 32'(res_vld), 0);
    check("R10 clear flags", 32'(res_corr | res_unc | res_cerr), 0);
    check("R10 clear loc", 32'(res_loc[23:12]), 0);
    command(9'h000);
    stored(2, 24'h123456);
    check("R9 unfinished block ignored", 32'(res_vld), 0);
    check("R9 unfinished flags", 32'(res_unc | res_cerr | res_corr), 0);
  endtask

  initial begin
    #100000000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_ignored;
    t_full_page;
    t_short_block;
    t_compare;
    t_clear;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule